// File: doc/BRIEF.md
# Dual-Lane Flash Command Snooper and Bit Striper

This block sits between a transmit byte stream and one or more SPI byte lanes. It watches the traffic on each chip-select phase. The first byte after a chip-select change is decoded as a serial-flash opcode. A known read opcode loads a header count that covers the address bytes and any dummy bytes. Each completed single-byte transfer lowers that count. When the count reaches zero the data path switches to bit striping. An opcode the block does not recognise puts it into pass-through until the next chip-select change.

Outside striping, each transmit byte is copied onto every lane, and only the byte returned on lane 0 goes to the receive side. In striping, LANES transmit bytes are gathered and their bits are dealt across the lanes. The bytes that come back are put back into their original order and emitted one per cycle. The SPI shifting is done by the lane logic outside this block. This block presents one word per transfer and waits for a completion pulse.

Top module: `flash_snoop_striper`

## Requirements
- R1: After reset, tx_ready_o is 1 and xfer_req_o, rx_valid_o and overflow_o are 0. The first byte sent is decoded as an opcode even when no chip-select change has come.
- R2: The plain-read opcode (default 0x03) is followed by exactly 3 single-byte header transfers. The next transfer is striped.
- R3: The fast-read opcode (default 0x0B) is followed by exactly 4 single-byte header transfers. The next transfer is striped.
- R4: The quad I/O read opcode (default 0xEB) is followed by exactly 5 single-byte header transfers. The next transfer is striped.
- R5: Any other opcode selects pass-through. Every later transfer is single-byte and unstriped until a chip-select change.
- R6: A cs_change_i pulse returns decoding to the opcode state from any state, including mid-header and striping. Bytes already gathered are kept and are sent under the new mode. The next single-byte transfer is decoded as the opcode.
- R7: Outside striping, one transmit byte is sent per transfer. It is copied into every byte lane of xfer_tx_o, where lane l is bits [8l+7:8l]. Only xfer_rx_i[7:0] is emitted.
- R8: In striping, a transfer starts only once LANES bytes are gathered. Number the gathered bits k = 8*byte + bit, with the first byte received as byte 0 and the LSB first. Bit k is sent on lane k mod LANES, at bit position k div LANES. The returned word is mapped back the inverse way, and byte 0 is emitted first.
- R9: If rx_full_i is 1 in the cycle xfer_done_i is seen, nothing is emitted. overflow_o pulses for one cycle, in the cycle after the completion.
- R10: xfer_req_o stays high with xfer_tx_o stable until xfer_done_i arrives, and then drops. No request is raised while received bytes are still being emitted.
- R11: tx_ready_o is 0 while the gather buffer holds LANES bytes.
- R12: Received bytes appear on rx_valid_o/rx_data_o in consecutive cycles, starting the cycle after the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_change_i | input | 1 | One-cycle pulse on any chip-select update |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Gather buffer can take a byte |
| xfer_req_o | output | 1 | Transfer request to the lanes, held until done |
| xfer_tx_o | output | 8*LANES | Per-lane transmit bytes, lane l at [8l+7:8l] |
| xfer_done_i | input | 1 | Lanes finished the transfer; xfer_rx_i valid |
| xfer_rx_i | input | 8*LANES | Per-lane received bytes |
| rx_full_i | input | 1 | Receive side cannot take data |
| rx_valid_o | output | 1 | Received byte valid |
| rx_data_o | output | 8 | Received byte |
| overflow_o | output | 1 | One-cycle pulse when a completion is dropped |

## Verification
The bench runs whole chip-select phases, one for each read opcode, one for an unknown opcode, and one with a chip-select change in the middle of the header. The count of copied transfers before the first striped one tells the three header lengths apart. It also separates pass-through from striping. Striping patterns with single set bits, alternating bits and full bytes make a lane swap, a bit-order reversal and a byte-order error each show up differently. Directed cases cover a completion while the receive side is full, a full gather buffer during a transfer, and a chip-select change while one striping byte waits.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    SN_OPCODE,
    SN_HEADER,
    SN_PASS,
    SN_STRIPE
  } snoop_state_e;
endpackage

// File: rtl/snoop_fsm.sv
module snoop_fsm #(
  parameter logic [7:0] OP_READ  = 8'h03,
  parameter logic [7:0] OP_FAST  = 8'h0B,
  parameter logic [7:0] OP_QUAD  = 8'hEB,
  parameter int         HDR_READ = 3,
  parameter int         HDR_FAST = 4,
  parameter int         HDR_QUAD = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_change_i,
  input  logic       step_i,
  input  logic [7:0] byte_i,
  output logic       stripe_o
);
  import snoop_pkg::*;

  localparam int HMAX = (HDR_READ > HDR_FAST) ?
                        ((HDR_READ > HDR_QUAD) ? HDR_READ : HDR_QUAD) :
                        ((HDR_FAST > HDR_QUAD) ? HDR_FAST : HDR_QUAD);
  localparam int HW = $clog2(HMAX + 1);

  snoop_state_e state_q;
  logic [HW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SN_OPCODE;
      left_q  <= '0;
    end else if (cs_change_i) begin
      state_q <= SN_OPCODE;
      left_q  <= '0;
    end else if (step_i) begin
      unique case (state_q)
        SN_OPCODE: begin
          if (byte_i == OP_READ) begin
            state_q <= SN_HEADER;
            left_q  <= HW'(HDR_READ);
          end else if (byte_i == OP_FAST) begin
            state_q <= SN_HEADER;
            left_q  <= HW'(HDR_FAST);
          end else if (byte_i == OP_QUAD) begin
            state_q <= SN_HEADER;
            left_q  <= HW'(HDR_QUAD);
          end else begin
            state_q <= SN_PASS;
          end
        end
        SN_HEADER: begin
          left_q <= left_q - 1'b1;
          if (left_q == HW'(1)) state_q <= SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  assign stripe_o = (state_q == SN_STRIPE);
endmodule

// File: rtl/lane_striper.sv
// UNSTRIPE=0: bit k -> lane k%LANES, position k/LANES. UNSTRIPE=1: inverse.
module lane_striper #(
  parameter int LANES    = 2,
  parameter bit UNSTRIPE = 1'b0
) (
  input  logic [LANES*8-1:0] data_i,
  output logic [LANES*8-1:0] data_o
);
  localparam int NB = LANES * 8;

  for (genvar k = 0; k < NB; k++) begin : g_bit
    localparam int LIDX = (k % LANES) * 8 + (k / LANES);
    if (UNSTRIPE) begin : g_inv
      assign data_o[k] = data_i[LIDX];
    end else begin : g_fwd
      assign data_o[LIDX] = data_i[k];
    end
  end
endmodule

// File: rtl/rx_serializer.sv
module rx_serializer #(
  parameter int LANES = 2,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CW-1:0]      nbytes_i,
  input  logic [LANES*8-1:0] data_i,
  output logic               valid_o,
  output logic [7:0]         data_o,
  output logic               busy_o
);
  logic [LANES*8-1:0] buf_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      buf_q <= data_i;
      cnt_q <= nbytes_i;
    end else if (cnt_q != '0) begin
      buf_q <= buf_q >> 8;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign busy_o  = valid_o;
  assign data_o  = buf_q[7:0];
endmodule

// File: rtl/flash_snoop_striper.sv
module flash_snoop_striper #(
  parameter int         LANES    = 2,
  parameter logic [7:0] OP_READ  = 8'h03,
  parameter logic [7:0] OP_FAST  = 8'h0B,
  parameter logic [7:0] OP_QUAD  = 8'hEB,
  parameter int         HDR_READ = 3,
  parameter int         HDR_FAST = 4,
  parameter int         HDR_QUAD = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_change_i,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic               xfer_req_o,
  output logic [LANES*8-1:0] xfer_tx_o,
  input  logic               xfer_done_i,
  input  logic [LANES*8-1:0] xfer_rx_i,
  input  logic               rx_full_i,
  output logic               rx_valid_o,
  output logic [7:0]         rx_data_o,
  output logic               overflow_o
);
  localparam int W  = LANES * 8;
  localparam int CW = $clog2(LANES + 1);

  logic          stripe_w, ser_busy_w;
  logic [W-1:0]  gbuf_q, gbuf_d, striped_w, unstriped_w, ser_data_w;
  logic [CW-1:0] gcnt_q, gcnt_d, need_w, consumed_w, ser_n_w;
  logic          accept_w, launch_w, done_w;
  logic          active_q, xstripe_q, ovf_q;
  logic [W-1:0]  xtx_q;
  logic [7:0]    sent_q;

  assign need_w     = stripe_w ? CW'(LANES) : CW'(1);
  assign tx_ready_o = (gcnt_q < CW'(LANES));
  assign accept_w   = tx_valid_i && tx_ready_o;
  assign launch_w   = !active_q && !ser_busy_w && (gcnt_q >= need_w);
  assign consumed_w = launch_w ? need_w : '0;
  assign done_w     = active_q && xfer_done_i;

  // gather buffer: drop consumed bytes, append the accepted one
  always_comb begin
    gbuf_d = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i + int'(consumed_w) < LANES)
        gbuf_d[i*8 +: 8] = gbuf_q[(i + int'(consumed_w))*8 +: 8];
    end
    if (accept_w)
      gbuf_d[(int'(gcnt_q) - int'(consumed_w))*8 +: 8] = tx_data_i;
    gcnt_d = gcnt_q - consumed_w + CW'(accept_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gbuf_q <= '0;
      gcnt_q <= '0;
    end else begin
      gbuf_q <= gbuf_d;
      gcnt_q <= gcnt_d;
    end
  end

  lane_striper #(.LANES(LANES), .UNSTRIPE(1'b0)) i_fwd (
    .data_i (gbuf_q),
    .data_o (striped_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      xstripe_q <= 1'b0;
      xtx_q     <= '0;
      sent_q    <= '0;
      ovf_q     <= 1'b0;
    end else begin
      ovf_q <= done_w && rx_full_i;
      if (launch_w) begin
        active_q  <= 1'b1;
        xstripe_q <= stripe_w;
        xtx_q     <= stripe_w ? striped_w : {LANES{gbuf_q[7:0]}};
        sent_q    <= gbuf_q[7:0];
      end else if (done_w) begin
        active_q <= 1'b0;
      end
    end
  end

  assign xfer_req_o = active_q;
  assign xfer_tx_o  = xtx_q;
  assign overflow_o = ovf_q;

  snoop_fsm #(
    .OP_READ (OP_READ),  .OP_FAST (OP_FAST),  .OP_QUAD (OP_QUAD),
    .HDR_READ(HDR_READ), .HDR_FAST(HDR_FAST), .HDR_QUAD(HDR_QUAD)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_change_i (cs_change_i),
    .step_i      (done_w && !xstripe_q),
    .byte_i      (sent_q),
    .stripe_o    (stripe_w)
  );

  lane_striper #(.LANES(LANES), .UNSTRIPE(1'b1)) i_inv (
    .data_i (xfer_rx_i),
    .data_o (unstriped_w)
  );

  assign ser_data_w = xstripe_q ? unstriped_w : {{(W-8){1'b0}}, xfer_rx_i[7:0]};
  assign ser_n_w    = xstripe_q ? CW'(LANES) : CW'(1);

  rx_serializer #(.LANES(LANES)) i_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (done_w && !rx_full_i),
    .nbytes_i (ser_n_w),
    .data_i   (ser_data_w),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .busy_o   (ser_busy_w)
  );
endmodule

// File: rtl/flash_snoop_striper_chk.sv
module flash_snoop_striper_chk #(
  parameter int LANES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xfer_req_o,
  input logic [LANES*8-1:0] xfer_tx_o,
  input logic               xfer_done_i,
  input logic               rx_full_i,
  input logic               rx_valid_o,
  input logic               overflow_o
);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_tx_o));

  a_r10_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_done_i |=> !xfer_req_o);

  a_r10_no_req_during_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !xfer_req_o);

  a_r9_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(xfer_done_i && xfer_req_o && rx_full_i));

  a_r9_ovf_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !rx_valid_o);

  a_r12_first_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(xfer_done_i && !rx_full_i));
endmodule

bind flash_snoop_striper flash_snoop_striper_chk #(.LANES(LANES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_req_o  (xfer_req_o),
  .xfer_tx_o   (xfer_tx_o),
  .xfer_done_i (xfer_done_i),
  .rx_full_i   (rx_full_i),
  .rx_valid_o  (rx_valid_o),
  .overflow_o  (overflow_o)
);

// File: tb/test_flash_snoop_striper.sv
`timescale 1ns/1ps
module test_flash_snoop_striper;
  localparam int LANES = 2;
  localparam int W = LANES * 8;

  typedef struct packed {
    logic       cs;
    logic       stripe;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [15:0] lrx;
    logic       full;
  } row_t;

  // stripe flag = mode expected from R1..R6
  localparam int NROWS = 34;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 8'h03, 8'h00, 16'h1234, 1'b0},  // R1 no cs: opcode; R2
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h5601, 1'b0},
    '{1'b0, 1'b0, 8'h10, 8'h00, 16'h0080, 1'b0},
    '{1'b0, 1'b0, 8'h20, 8'h00, 16'hFF7E, 1'b0},
    '{1'b0, 1'b1, 8'hA5, 8'h3C, 16'h9E61, 1'b0},  // R2 striping
    '{1'b0, 1'b1, 8'hFF, 8'h00, 16'h0F0F, 1'b1},  // R9 full
    '{1'b0, 1'b1, 8'h01, 8'h80, 16'h8001, 1'b0},
    '{1'b1, 1'b0, 8'h0B, 8'h00, 16'h00AA, 1'b0},  // R3
    '{1'b0, 1'b0, 8'h01, 8'h00, 16'h0011, 1'b0},
    '{1'b0, 1'b0, 8'h02, 8'h00, 16'h0022, 1'b0},
    '{1'b0, 1'b0, 8'h03, 8'h00, 16'h0033, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h0044, 1'b0},
    '{1'b0, 1'b1, 8'h5A, 8'hC3, 16'hAAAA, 1'b0},  // R3 striping
    '{1'b1, 1'b0, 8'h55, 8'h00, 16'h0101, 1'b0},  // R5 unknown
    '{1'b0, 1'b0, 8'h61, 8'h00, 16'h0202, 1'b0},
    '{1'b0, 1'b0, 8'h62, 8'h00, 16'h0303, 1'b0},
    '{1'b0, 1'b0, 8'h63, 8'h00, 16'h0404, 1'b0},
    '{1'b0, 1'b0, 8'h64, 8'h00, 16'h0505, 1'b0},
    '{1'b0, 1'b0, 8'h65, 8'h00, 16'h0606, 1'b0},
    '{1'b1, 1'b0, 8'hEB, 8'h00, 16'h0707, 1'b0},  // R4
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h0808, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h0909, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h0A0A, 1'b0},
    '{1'b0, 1'b0, 8'hFF, 8'h00, 16'h0B0B, 1'b0},
    '{1'b0, 1'b0, 8'hFF, 8'h00, 16'h0C0C, 1'b0},
    '{1'b0, 1'b1, 8'h96, 8'h69, 16'h00FF, 1'b0},  // R4 striping
    '{1'b1, 1'b0, 8'h03, 8'h00, 16'h0D0D, 1'b0},  // R6 cs mid-header
    '{1'b0, 1'b0, 8'hAA, 8'h00, 16'h0E0E, 1'b0},
    '{1'b1, 1'b0, 8'h0B, 8'h00, 16'h0F0F, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h1010, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h1111, 1'b0},  // would stripe without R6
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h1212, 1'b0},
    '{1'b0, 1'b0, 8'h00, 8'h00, 16'h1313, 1'b0},
    '{1'b0, 1'b1, 8'h12, 8'h48, 16'hC3A5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_change_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic tx_valid_i = 1'b0;
  logic tx_ready_o;
  logic xfer_req_o;
  logic [W-1:0] xfer_tx_o;
  logic xfer_done_i = 1'b0;
  logic [W-1:0] xfer_rx_i = '0;
  logic rx_full_i = 1'b0;
  logic rx_valid_o;
  logic [7:0] rx_data_o;
  logic overflow_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  flash_snoop_striper #(.LANES(LANES)) i_flash_snoop_striper (
    .clk_i(clk), .rst_ni(rst_ni), .cs_change_i(cs_change_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o), .xfer_done_i(xfer_done_i),
    .xfer_rx_i(xfer_rx_i), .rx_full_i(rx_full_i), .rx_valid_o(rx_valid_o),
    .rx_data_o(rx_data_o), .overflow_o(overflow_o)
  );

  function automatic logic [W-1:0] model_stripe(input logic [W-1:0] d);
    logic [W-1:0] r = '0;
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < 8; p++)
        r[l*8 + p] = d[p*LANES + l];
    return r;
  endfunction

  function automatic logic [W-1:0] model_unstripe(input logic [W-1:0] d);
    logic [W-1:0] r = '0;
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < 8; p++)
        r[p*LANES + l] = d[l*8 + p];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_valid_i = 1'b1;
    tx_data_i  = b;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic pulse_cs();
    @(negedge clk);
    cs_change_i = 1'b1;
    @(negedge clk);
    cs_change_i = 1'b0;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (!xfer_req_o && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(xfer_req_o, req, "request raised", 32'(xfer_req_o), 32'd1);
  endtask

  task automatic complete(input logic [15:0] lrx, input logic full, input logic stripe);
    logic [7:0] got [4];
    int n = 0;
    int ov = 0;
    bit gap = 1'b0;
    bit clash = 1'b0;
    logic [W-1:0] un;
    @(negedge clk);
    xfer_rx_i = lrx; xfer_done_i = 1'b1; rx_full_i = full;
    @(negedge clk);
    xfer_done_i = 1'b0; rx_full_i = 1'b0;
    check(!xfer_req_o, "R10", "request dropped after done", 32'(xfer_req_o), 32'd0);
    for (int i = 0; i < 4; i++) begin
      if (rx_valid_o) begin
        if (n != i) gap = 1'b1;
        got[n] = rx_data_o;
        n++;
      end
      if (overflow_o) ov++;
      if (rx_valid_o && xfer_req_o) clash = 1'b1;
      @(negedge clk);
    end
    check(!clash, "R10", "no request while emitting", 32'(clash), 32'd0);
    if (full) begin
      check(n == 0, "R9", "bytes emitted when full", 32'(n), 32'd0);
      check(ov == 1, "R9", "overflow pulses", 32'(ov), 32'd1);
    end else begin
      check(ov == 0, "R9", "no overflow", 32'(ov), 32'd0);
      check(!gap, "R12", "output starts next cycle, back to back", 32'(gap), 32'd0);
      if (stripe) begin
        un = model_unstripe(lrx);
        check(n == 2, "R8", "byte count", 32'(n), 32'd2);
        check({got[1], got[0]} == un, "R8", "de-striped bytes", {got[1], got[0]}, 32'(un));
      end else begin
        check(n == 1, "R7", "byte count", 32'(n), 32'd1);
        check(got[0] == lrx[7:0], "R7", "lane 0 byte", 32'(got[0]), 32'(lrx[7:0]));
      end
    end
  endtask

  task automatic run_row(input row_t r);
    logic [W-1:0] exp_tx;
    logic [W-1:0] held;
    string req;
    req = r.stripe ? "R8" : "R7";
    exp_tx = r.stripe ? model_stripe({r.b1, r.b0}) : {r.b0, r.b0};
    if (r.cs) pulse_cs();
    send_byte(r.b0);
    if (r.stripe) send_byte(r.b1);
    wait_req(req);
    check(xfer_tx_o == exp_tx, req, "lane transmit word", 32'(xfer_tx_o), 32'(exp_tx));
    held = xfer_tx_o;
    repeat (2) @(negedge clk);
    check(xfer_req_o && xfer_tx_o == held, "R10", "request held stable",
          32'(xfer_tx_o), 32'(held));
    complete(r.lrx, r.full, r.stripe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_ready_o == 1'b1, "R1", "ready in reset", 32'(tx_ready_o), 32'd1);
    check(!xfer_req_o && !rx_valid_o && !overflow_o, "R1", "outputs idle in reset",
          {29'd0, xfer_req_o, rx_valid_o, overflow_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

    // R11 and R10: fill the buffer while a striped transfer is in flight
    begin
      logic [W-1:0] exp_tx;
      send_byte(8'hF0);
      send_byte(8'h0F);
      wait_req("R8");
      send_byte(8'h81);
      send_byte(8'h7E);
      @(negedge clk);
      check(tx_ready_o == 1'b0, "R11", "ready low with full buffer", 32'(tx_ready_o), 32'd0);
      check(xfer_tx_o == model_stripe(16'h0FF0), "R8", "first striped word",
            32'(xfer_tx_o), 32'(model_stripe(16'h0FF0)));
      complete(16'h3355, 1'b0, 1'b1);
      wait_req("R10");
      exp_tx = model_stripe(16'h7E81);
      check(xfer_tx_o == exp_tx, "R8", "buffered word sent next",
            32'(xfer_tx_o), 32'(exp_tx));
      complete(16'hC001, 1'b0, 1'b1);
    end

    // R6: one striping byte waits, cs change sends it as an opcode
    begin
      send_byte(8'h03);
      repeat (3) @(negedge clk);
      check(!xfer_req_o, "R8", "no start with one of two bytes", 32'(xfer_req_o), 32'd0);
      pulse_cs();
      wait_req("R6");
      check(xfer_tx_o == 16'h0303, "R6", "waiting byte sent copied",
            32'(xfer_tx_o), 32'h0303);
      complete(16'h0077, 1'b0, 1'b0);
      run_row('{1'b0, 1'b0, 8'h01, 8'h00, 16'h0001, 1'b0});
      run_row('{1'b0, 1'b0, 8'h02, 8'h00, 16'h0002, 1'b0});
      run_row('{1'b0, 1'b0, 8'h03, 8'h00, 16'h0003, 1'b0});
      run_row('{1'b0, 1'b1, 8'hC6, 8'h39, 16'h6C93, 1'b0});  // R6 decoded as read
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule